// File: doc/BRIEF.md
# UART receive command controller

This block turns single-cycle writes to a 32-bit receive command word into the control state of a UART receiver. Six command bits act once, on the cycle of the write: enabling or disabling reception, flushing the receiver logic, emptying the receive FIFO, and locking or unlocking the FIFO write path. The command bits are write-only, and the read data port returns zero. Only two pieces of state persist between writes: the reception-enable flag and the FIFO write-lock flag.

On the datapath side, the receiver offers each completed character with a one-cycle strobe. The block writes the character into a small internal FIFO only when writes are allowed. A character offered while the FIFO is locked or full is discarded, and a one-cycle dropped pulse marks the loss. Locking does not stop reception. In multidrop networks software locks the FIFO, and an address-match pulse from the receiver unlocks it while multidrop mode is selected. The matching address character and the characters after it are then stored.

Top module: `uart_rx_cmd_ctrl`

## Requirements
- R1: After reset, rx_enable is 0, fifo_locked is 0, the FIFO is empty, and rx_flush, fifo_clear and char_dropped are 0.
- R2: A write with bit 7 set makes rx_enable 1 from the next cycle. A write with bit 6 set makes it 0. When bits 7 and 6 are set in the same write, rx_enable ends at 0.
- R3: A write with bit 5 set raises rx_flush for exactly the one cycle after the write. It sets rx_enable to 1 and fifo_locked to 0, and leaves the FIFO contents and count unchanged.
- R4: A write with bit 4 set empties the FIFO, so fifo_count is 0 from the next cycle. It also raises fifo_clear for that one cycle.
- R5: A write with bit 3 set makes fifo_locked 1 and a write with bit 2 set makes it 0. When bits 3 and 2 are set in the same write, fifo_locked ends at 1.
- R6: When bit 5 is written together with bit 6, rx_enable ends at 0. When bit 5 is written together with bit 3, fifo_locked ends at 1.
- R7: Bits written as 0, reserved bits 31:8 and 1:0, and any data present while cmd_wr is low leave rx_enable, fifo_locked and the FIFO unchanged.
- R8: cmd_rdata reads as zero at all times, including after command writes.
- R9: A character offered while the FIFO is unlocked and not full is stored. Characters are read back in the order they arrived, and no dropped pulse is produced.
- R10: A character offered while fifo_locked is 1 or the FIFO is full produces a one-cycle char_dropped pulse in the next cycle and leaves fifo_count unchanged. rx_enable is not affected.
- R11: An addr_match pulse while multidrop_mode is 1 unlocks the FIFO and stores the character offered in the same cycle. While multidrop_mode is 0, addr_match has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Single-cycle write strobe for the command word |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Read view of the command word, always zero |
| multidrop_mode | input | 1 | Selects multidrop address filtering |
| addr_match | input | 1 | Receiver pulse: the current character matched the station address |
| rx_char_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_char_data | input | DATA_W | Received character |
| fifo_rd | input | 1 | Pop the head of the receive FIFO |
| fifo_rd_data | output | DATA_W | Head of the receive FIFO (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no characters |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH characters |
| fifo_count | output | CNT_W | Number of stored characters |
| rx_enable | output | 1 | Reception enabled |
| fifo_locked | output | 1 | FIFO write path locked |
| rx_flush | output | 1 | One-cycle reset pulse for the receiver logic |
| fifo_clear | output | 1 | One-cycle pulse marking a FIFO flush |
| char_dropped | output | 1 | One-cycle pulse: an offered character was discarded |

## Verification
The bench concentrates on writes that combine conflicting bits. It covers enable with disable, lock with unlock, and a flush together with a disable or a lock. A design with a priority reversed would leave reception on or the FIFO open. It checks that a flush keeps the stored characters: a design that reused the FIFO clear for it would lose the three queued bytes that the scoreboard later expects. It offers characters while the FIFO is locked, while it is full, and with an address match both outside and inside multidrop mode. A wrong gate would either store a byte the scoreboard did not queue or drop one it did.

// File: rtl/uart_rxcmd_pkg.sv
package uart_rxcmd_pkg;

   localparam int unsigned CMD_W = 32;

   // Command bit positions: software decodes these.
   localparam int unsigned BIT_ENA    = 7;
   localparam int unsigned BIT_DIS    = 6;
   localparam int unsigned BIT_FLUSH  = 5;
   localparam int unsigned BIT_CLR    = 4;
   localparam int unsigned BIT_LOCK   = 3;
   localparam int unsigned BIT_UNLOCK = 2;

   typedef struct packed {
      logic ena;
      logic dis;
      logic flush;
      logic clr;
      logic lock;
      logic unlock;
   } rx_cmd_t;

endpackage

// File: rtl/rxcmd_decode.sv
module rxcmd_decode
   import uart_rxcmd_pkg::*;
(
   input  logic             wr_i,
   input  logic [CMD_W-1:0] wdata_i,
   output rx_cmd_t          cmd_o
);

   // Reserved positions carry no action.
   logic unused_rsvd;
   assign unused_rsvd = ^{wdata_i[CMD_W-1:BIT_ENA+1], wdata_i[BIT_UNLOCK-1:0]};

   always_comb begin
      cmd_o        = '0;
      cmd_o.ena    = wr_i & wdata_i[BIT_ENA];
      cmd_o.dis    = wr_i & wdata_i[BIT_DIS];
      cmd_o.flush  = wr_i & wdata_i[BIT_FLUSH];
      cmd_o.clr    = wr_i & wdata_i[BIT_CLR];
      cmd_o.lock   = wr_i & wdata_i[BIT_LOCK];
      cmd_o.unlock = wr_i & wdata_i[BIT_UNLOCK];
   end

endmodule

// File: rtl/rxcmd_state.sv
module rxcmd_state
   import uart_rxcmd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  rx_cmd_t cmd_i,
   input  logic    match_unlock_i,
   output logic    enable_o,
   output logic    locked_o,
   output logic    flush_o,
   output logic    clear_o
);

   logic en_d, lock_d;

   always_comb begin
      en_d = enable_o;
      if (cmd_i.flush || cmd_i.ena) en_d = 1'b1;
      if (cmd_i.dis)                en_d = 1'b0;   // disable has the last word

      lock_d = locked_o;
      if (cmd_i.flush || cmd_i.unlock || match_unlock_i) lock_d = 1'b0;
      if (cmd_i.lock)                                    lock_d = 1'b1;   // lock wins
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_o <= 1'b0;
         locked_o <= 1'b0;
         flush_o  <= 1'b0;
         clear_o  <= 1'b0;
      end else begin
         enable_o <= en_d;
         locked_o <= lock_d;
         flush_o  <= cmd_i.flush;
         clear_o  <= cmd_i.clr;
      end
   end

endmodule

// File: rtl/rxcmd_fifo.sv
module rxcmd_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              empty_o,
   output logic              full_o,
   output logic [CNT_W-1:0]  count_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp, wp_nxt, rp_nxt;
   logic              do_wr, do_rd;

   assign empty_o = (count_o == '0);
   assign full_o  = (count_o == CNT_W'(DEPTH));
   assign do_wr   = wr_i & ~full_o & ~clr_i;
   assign do_rd   = rd_i & ~empty_o & ~clr_i;
   assign rdata_o = mem[rp];

   // Pointer advance: free wrap for powers of two, explicit wrap otherwise.
   if ((1 << PTR_W) == DEPTH) begin : g_wrap_pow2
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nxt = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         count_o <= '0;
      end else if (clr_i) begin
         wp      <= '0;
         rp      <= '0;
         count_o <= '0;
      end else begin
         if (do_wr) wp <= wp_nxt;
         if (do_rd) rp <= rp_nxt;
         count_o <= count_o + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end

endmodule

// File: rtl/uart_rx_cmd_ctrl.sv
module uart_rx_cmd_ctrl
   import uart_rxcmd_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FIFO_DEPTH = 4,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   output logic [CMD_W-1:0]  cmd_rdata,
   input  logic              multidrop_mode,
   input  logic              addr_match,
   input  logic              rx_char_valid,
   input  logic [DATA_W-1:0] rx_char_data,
   input  logic              fifo_rd,
   output logic [DATA_W-1:0] fifo_rd_data,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic [CNT_W-1:0]  fifo_count,
   output logic              rx_enable,
   output logic              fifo_locked,
   output logic              rx_flush,
   output logic              fifo_clear,
   output logic              char_dropped
);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_rx_cmd_ctrl: FIFO_DEPTH must be at least 2");
   end
   if (DATA_W < 1 || DATA_W > CMD_W) begin : g_bad_width
      $error("uart_rx_cmd_ctrl: DATA_W must lie in 1..32");
   end

   rx_cmd_t cmd;
   logic    match_unlock, store_ok, push, drop_q;

   // Command bits are write-only.
   assign cmd_rdata = '0;

   rxcmd_decode i_decode (
      .wr_i    (cmd_wr),
      .wdata_i (cmd_wdata),
      .cmd_o   (cmd)
   );

   assign match_unlock = multidrop_mode & addr_match;

   rxcmd_state i_state (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_i          (cmd),
      .match_unlock_i (match_unlock),
      .enable_o       (rx_enable),
      .locked_o       (fifo_locked),
      .flush_o        (rx_flush),
      .clear_o        (fifo_clear)
   );

   // A matching address character already sees the lock lifted.
   assign store_ok = ~(fifo_locked & ~match_unlock) & ~fifo_full & ~cmd.clr;
   assign push     = rx_char_valid & store_ok;

   rxcmd_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (cmd.clr),
      .wr_i    (push),
      .wdata_i (rx_char_data),
      .rd_i    (fifo_rd),
      .rdata_o (fifo_rd_data),
      .empty_o (fifo_empty),
      .full_o  (fifo_full),
      .count_o (fifo_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drop_q <= 1'b0;
      else        drop_q <= rx_char_valid & ~store_ok;
   end
   assign char_dropped = drop_q;

endmodule

// File: rtl/uart_rx_cmd_ctrl_chk.sv
module uart_rx_cmd_ctrl_chk
   import uart_rxcmd_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 4,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_wr,
   input logic [CMD_W-1:0] cmd_wdata,
   input logic             multidrop_mode,
   input logic             addr_match,
   input logic             rx_char_valid,
   input logic             fifo_rd,
   input logic             rx_enable,
   input logic             fifo_locked,
   input logic             rx_flush,
   input logic             fifo_clear,
   input logic             char_dropped,
   input logic             fifo_empty,
   input logic [CNT_W-1:0] fifo_count
);

   // R2
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[BIT_DIS] |=> !rx_enable);

   // R5
   lock_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[BIT_LOCK] |=> fifo_locked);

   // R3
   flush_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[BIT_FLUSH] && !cmd_wdata[BIT_DIS] |=> rx_enable && rx_flush);

   // R7
   no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(rx_enable));

   // R4
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[BIT_CLR] |=> fifo_empty && fifo_clear);

   // R10
   locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_valid && fifo_locked && !(multidrop_mode && addr_match) && !fifo_rd
      |=> char_dropped && $stable(fifo_count));

   // R11
   match_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      multidrop_mode && addr_match && !(cmd_wr && cmd_wdata[BIT_LOCK]) |=> !fifo_locked);

   // R9
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(FIFO_DEPTH));

endmodule

bind uart_rx_cmd_ctrl uart_rx_cmd_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_wr         (cmd_wr),
   .cmd_wdata      (cmd_wdata),
   .multidrop_mode (multidrop_mode),
   .addr_match     (addr_match),
   .rx_char_valid  (rx_char_valid),
   .fifo_rd        (fifo_rd),
   .rx_enable      (rx_enable),
   .fifo_locked    (fifo_locked),
   .rx_flush       (rx_flush),
   .fifo_clear     (fifo_clear),
   .char_dropped   (char_dropped),
   .fifo_empty     (fifo_empty),
   .fifo_count     (fifo_count)
);

// File: tb/test_uart_rx_cmd_ctrl.sv
module test_uart_rx_cmd_ctrl;

   localparam int unsigned DW    = 8;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [31:0]   cmd_wdata = '0;
   logic [31:0]   cmd_rdata;
   logic          multidrop_mode = 1'b0;
   logic          addr_match = 1'b0;
   logic          rx_char_valid = 1'b0;
   logic [DW-1:0] rx_char_data = '0;
   logic          fifo_rd = 1'b0;
   logic [DW-1:0] fifo_rd_data;
   logic          fifo_empty, fifo_full;
   logic [CW-1:0] fifo_count;
   logic          rx_enable, fifo_locked, rx_flush, fifo_clear, char_dropped;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [DW-1:0] sb_q[$];

   always #5 clk = ~clk;

   uart_rx_cmd_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) i_uart_rx_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .multidrop_mode(multidrop_mode),
      .addr_match(addr_match), .rx_char_valid(rx_char_valid),
      .rx_char_data(rx_char_data), .fifo_rd(fifo_rd),
      .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
      .fifo_full(fifo_full), .fifo_count(fifo_count), .rx_enable(rx_enable),
      .fifo_locked(fifo_locked), .rx_flush(rx_flush), .fifo_clear(fifo_clear),
      .char_dropped(char_dropped)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Moves to 2 ns after the next rising edge.
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr_cmd(input logic [31:0] d);
      cmd_wr = 1'b1; cmd_wdata = d;
      step();
      cmd_wr = 1'b0; cmd_wdata = '0;
   endtask

   // Driver: offers one character and queues it if it should be stored.
   task automatic offer(input logic [DW-1:0] d, input bit match, input bit expect_store,
                        input string req);
      rx_char_valid = 1'b1; rx_char_data = d; addr_match = match;
      step();
      rx_char_valid = 1'b0; addr_match = 1'b0;
      if (expect_store) sb_q.push_back(d);
      chk(req, char_dropped, !expect_store);
   endtask

   task automatic drain(input string req);
      while (!fifo_empty) begin
         fifo_rd = 1'b1;
         step();
      end
      fifo_rd = 1'b0;
      chk(req, sb_q.size(), 0);
   endtask

   // Monitor: compares each popped character with the scoreboard.
   always @(negedge clk) begin
      if (rst_n && fifo_rd && !fifo_empty) begin
         if (sb_q.size() == 0) begin
            chk("R9 unexpected char", fifo_rd_data, 'hx);
         end else begin
            chk("R9 order", fifo_rd_data, sb_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 rx_enable", rx_enable, 0);
      chk("R1 fifo_locked", fifo_locked, 0);
      chk("R1 fifo_empty", fifo_empty, 1);
      chk("R1 pulses", {rx_flush, fifo_clear, char_dropped}, 0);
      chk("R8 rdata after reset", cmd_rdata, 0);

      // R2 enable / disable / both
      wr_cmd(32'h80); chk("R2 enable", rx_enable, 1);
      wr_cmd(32'h40); chk("R2 disable", rx_enable, 0);
      wr_cmd(32'h80); wr_cmd(32'hC0); chk("R2 both -> off", rx_enable, 0);
      // R7 zero bits and no strobe have no effect
      wr_cmd(32'h80);
      wr_cmd(32'hFFFF_FF03); chk("R7 zero/reserved bits", {rx_enable, fifo_locked}, 2'b10);
      cmd_wdata = 32'h0000_005C; step(); cmd_wdata = '0;
      chk("R7 data without cmd_wr", {rx_enable, fifo_locked, fifo_clear}, 3'b100);

      // R9 storage while unlocked
      offer(8'hA1, 1'b0, 1'b1, "R9 store A");
      offer(8'hB2, 1'b0, 1'b1, "R9 store B");
      offer(8'hC3, 1'b0, 1'b1, "R9 store C");
      chk("R9 count", fifo_count, 3);
      // R8 reads zero after a command write
      wr_cmd(32'h0000_0084); chk("R8 rdata after write", cmd_rdata, 0);

      // R5 lock / unlock / both, R10 drop while locked
      wr_cmd(32'h08); chk("R5 lock", fifo_locked, 1);
      offer(8'hD4, 1'b0, 1'b0, "R10 drop locked");
      chk("R10 count unchanged", fifo_count, 3);
      chk("R10 reception continues", rx_enable, 1);
      step(); chk("R10 drop pulse one cycle", char_dropped, 0);
      wr_cmd(32'h04); chk("R5 unlock", fifo_locked, 0);
      wr_cmd(32'h0C); chk("R5 both -> locked", fifo_locked, 1);

      // R3 flush keeps contents, enables, unlocks
      wr_cmd(32'h40);
      wr_cmd(32'h20);
      chk("R3 rx_flush pulse", rx_flush, 1);
      chk("R3 enable+unlock", {rx_enable, fifo_locked}, 2'b10);
      chk("R3 contents kept", fifo_count, 3);
      step(); chk("R3 pulse one cycle", rx_flush, 0);

      // R6 priorities with flush
      wr_cmd(32'h60); chk("R6 flush+disable", rx_enable, 0);
      wr_cmd(32'h28); chk("R6 flush+lock", {rx_enable, fifo_locked}, 2'b11);
      wr_cmd(32'h04);

      drain("R9 drain A B C");

      // R10 full, R4 clear
      for (int i = 0; i < DEPTH; i++) offer(DW'(8'h10 + i), 1'b0, 1'b1, "R9 fill");
      chk("R10 full flag", fifo_full, 1);
      offer(8'hEE, 1'b0, 1'b0, "R10 drop full");
      chk("R10 count at depth", fifo_count, DEPTH);
      wr_cmd(32'h10);
      sb_q.delete();
      chk("R4 fifo_clear pulse", fifo_clear, 1);
      chk("R4 empty", {fifo_empty, fifo_count}, {1'b1, CW'(0)});
      step(); chk("R4 pulse one cycle", fifo_clear, 0);

      // R11 address match
      wr_cmd(32'h08);
      multidrop_mode = 1'b0;
      offer(8'h55, 1'b1, 1'b0, "R11 match ignored outside multidrop");
      chk("R11 still locked", fifo_locked, 1);
      multidrop_mode = 1'b1;
      offer(8'h66, 1'b0, 1'b0, "R11 no match dropped");
      offer(8'h77, 1'b1, 1'b1, "R11 match char stored");
      chk("R11 unlocked", fifo_locked, 0);
      offer(8'h88, 1'b0, 1'b1, "R11 following char stored");
      drain("R11 drain");

      step();
      finish_run();
   end

endmodule